// File: doc/BRIEF.md
# Phase-Shifted Multicarrier PWM Generator

This block produces the switch commands for one leg of a five-level clamped/flying-capacitor converter. A set of triangular carriers shares one period. Each carrier is displaced from the previous one by an equal fraction of that period, a quarter period in the default four-carrier build. One signed modulation reference is compared against every carrier. Each comparison result drives a fixed group of gate bits. The first two carriers each drive a complementary pair. Every later carrier drives two in-phase bits and two bits complementary to them.

The reference is captured once per period, when the first carrier reaches its valley, so it stays constant across a whole carrier period. Besides the gates, the block reports the output level: the number of carriers whose comparison is currently true. Dead time, measurement and regulation belong to other blocks.

Top module: `mcpwm_phase_leg`

## Requirements
- R1: While `rst_n` is low, every bit of `gate_o` is 0 and `level_o` is 0.
- R2: Each carrier counts one step per clock, 0 up to `peak_i` and back down, so a full period lasts 2·`peak_i` cycles. After reset, carrier k (k = 0 to NCAR−1) starts at phase k·2·`peak_i`/NCAR. Phase p maps to the value p when p ≤ `peak_i` and to 2·`peak_i` − p otherwise. `peak_i` is even, at least 2, and held constant between resets.
- R3: Carrier k is "on" when 2·c_k < ref_held + `peak_i`, with the held reference a signed value in [−`peak_i`, +`peak_i`]. The gates and the level reflect the carrier values and the held reference of the previous cycle, one register stage.
- R4: For carriers 0 and 1, gate bit 2k carries the carrier's on state and gate bit 2k+1 carries its inverse.
- R5: For a carrier k ≥ 2, the group of four bits starting at bit 4k−4 is ordered on, inverse, on, inverse. The two "on" bits are equal at all times, and so are the two inverse bits.
- R6: `level_o` equals the number of carriers that are on (0 to NCAR). It updates in the same cycle as the gates, whether or not gating is enabled.
- R7: `ref_i` is captured only on a clock edge where carrier 0 holds the value 0. A change of `ref_i` at any other point has no effect on the outputs until that capture.
- R8: An edge with `en_i` low clears all gate bits. The carriers keep running meanwhile, and `level_o` keeps tracking them.
- R9: With a held reference of −`peak_i`, no carrier is ever on and the level stays 0. With +`peak_i`, every carrier is on except in the single cycle when that carrier sits at its peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also preloads the carrier offsets from `peak_i` |
| en_i | input | 1 | Gate enable; when low, all gates are forced to 0 |
| peak_i | input | CNT_W | Carrier peak count (half period in cycles) |
| ref_i | input | CNT_W+1 | Signed modulation reference, scaled to ±`peak_i` |
| gate_o | output | 4·NCAR−4 | Switch commands, grouped per carrier as in R4/R5 |
| level_o | output | clog2(NCAR+1) | Number of carriers currently on |

## Verification
The bench builds the block with four carriers and an 8-bit counter. It runs with peaks of 8 and 6, so each period lasts only 16 or 12 cycles and every carrier offset falls on a whole cycle. Short periods let each scenario sweep several complete periods and cover both reference extremes and the valley capture point. They also cover mid-period reference changes and an enable drop, all within a few hundred cycles. The second peak value moves the quarter offsets to odd phases (3 and 9). This exercises the preload arithmetic on values that do not coincide with the peak.

// File: rtl/mcpwm_pkg.sv
// Shared types and helpers for the multicarrier PWM leg.
// Assumes at least two carriers.
package mcpwm_pkg;

    // Counting direction of one triangular carrier
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Number of gate bits for a given carrier count: two carriers
    // drive pairs, every further carrier drives a group of four.
    function automatic int gate_count(input int ncar);
        return 4 * ncar - 4;
    endfunction

    // Index of the first gate bit owned by carrier k
    function automatic int gate_base(input int k);
        return (k < 2) ? 2 * k : 4 * k - 4;
    endfunction

endpackage

// File: rtl/mcpwm_carrier.sv
// One triangular carrier: an up/down counter between 0 and peak.
// On reset it is preloaded to phase IDX*2*peak/NCAR of the period,
// which places the carriers at equal offsets. Assumes peak >= 2 and
// that peak only changes while reset is held.
module mcpwm_carrier
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCAR  = 4,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] peak,
    output logic [CNT_W-1:0] cnt,
    output logic             valley
);
    localparam int PW = CNT_W + $clog2(2 * NCAR) + 2;

    logic [PW-1:0] prod;
    logic [PW-1:0] ofs;
    logic [PW-1:0] peak_w;
    logic [PW-1:0] pre_w;
    dir_e          pre_dir;
    dir_e          dir;

    // Purpose: derive the preload value and direction from the offset phase
    always_comb begin
        peak_w = PW'(peak);
        prod   = PW'(2 * IDX) * peak_w;
        ofs    = prod / PW'(NCAR);
        if (ofs < peak_w) begin
            pre_w   = ofs;
            pre_dir = DIR_UP;
        end else if (ofs == peak_w) begin
            pre_w   = ofs;
            pre_dir = DIR_DOWN;
        end else begin
            pre_w   = (peak_w << 1) - ofs;
            pre_dir = DIR_DOWN;
        end
    end

    // Purpose: step the triangle one count per clock, turning at 0 and peak
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= pre_w[CNT_W-1:0];
            dir <= pre_dir;
        end else begin
            case (dir)
                DIR_UP: begin
                    if (cnt >= peak - 1'b1) begin
                        cnt <= peak;
                        dir <= DIR_DOWN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt <= CNT_W'(1)) begin
                        cnt <= '0;
                        dir <= DIR_UP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // Purpose: flag the valley, used to time the reference capture
    assign valley = (cnt == '0);

endmodule

// File: rtl/mcpwm_ref_hold.sv
// Holds the modulation reference for a whole carrier period.
// Captures the input on edges where load is high; clears to 0 on reset.
module mcpwm_ref_hold #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic signed [CNT_W:0] ref_in,
    output logic signed [CNT_W:0] ref_q
);
    // Purpose: sample the reference at the carrier valley only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (load) begin
            ref_q <= ref_in;
        end
    end
endmodule

// File: rtl/mcpwm_gate_map.sv
// Compares every carrier with the held reference and registers the gate
// groups and the level count. Carriers 0 and 1 drive a complementary
// pair; later carriers drive on/inverse/on/inverse groups.
// Assumes the reference stays within +/- peak.
module mcpwm_gate_map
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCAR  = 4,
    parameter int NG    = 12,
    parameter int LW    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [CNT_W-1:0]       peak,
    input  logic signed [CNT_W:0]  ref_q,
    input  logic [NCAR*CNT_W-1:0]  cnt_flat,
    output logic [NG-1:0]          gate,
    output logic [LW-1:0]          level
);
    localparam int XW = CNT_W + 3;

    logic [NCAR-1:0]      on;
    logic [NG-1:0]        gate_d;
    logic [LW-1:0]        level_d;
    logic signed [XW-1:0] thresh;

    // Purpose: threshold = reference shifted to the 0..2*peak range
    assign thresh = XW'(ref_q) + $signed({3'b000, peak});

    // Purpose: one comparator per carrier against the doubled count
    for (genvar k = 0; k < NCAR; k++) begin : g_cmp
        logic signed [XW-1:0] dbl;
        assign dbl   = $signed({2'b00, cnt_flat[k*CNT_W +: CNT_W], 1'b0});
        assign on[k] = (dbl < thresh);
    end

    // Purpose: route each comparison to its gate group
    for (genvar k = 0; k < NCAR; k++) begin : g_map
        localparam int B = gate_base(k);
        if (k < 2) begin : g_pair
            assign gate_d[B]     = on[k];
            assign gate_d[B + 1] = ~on[k];
        end else begin : g_quad
            assign gate_d[B]     = on[k];
            assign gate_d[B + 1] = ~on[k];
            assign gate_d[B + 2] = on[k];
            assign gate_d[B + 3] = ~on[k];
        end
    end

    // Purpose: count the carriers that are currently on
    always_comb begin
        level_d = '0;
        for (int k = 0; k < NCAR; k++) begin
            level_d = level_d + LW'(on[k]);
        end
    end

    // Purpose: register gates (masked by enable) and the level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate  <= '0;
            level <= '0;
        end else begin
            gate  <= en ? gate_d : '0;
            level <= level_d;
        end
    end
endmodule

// File: rtl/mcpwm_phase_leg.sv
// Top of the multicarrier PWM leg: NCAR phase-shifted carriers, a
// reference captured at the valley of carrier 0, and the gate mapping.
// Assumes peak_i is even, at least 2, and changed only under reset.
module mcpwm_phase_leg
    import mcpwm_pkg::*;
#(
    parameter int NCAR  = 4,
    parameter int CNT_W = 16,
    localparam int NG   = 4 * NCAR - 4,
    localparam int LW   = $clog2(NCAR + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic [CNT_W-1:0]      peak_i,
    input  logic signed [CNT_W:0] ref_i,
    output logic [NG-1:0]         gate_o,
    output logic [LW-1:0]         level_o
);
    logic [NCAR*CNT_W-1:0] cnt_flat;
    logic [NCAR-1:0]       valley;
    logic signed [CNT_W:0] ref_q;

    // Purpose: instantiate one carrier per offset slot
    for (genvar k = 0; k < NCAR; k++) begin : g_car
        mcpwm_carrier #(
            .CNT_W (CNT_W),
            .NCAR  (NCAR),
            .IDX   (k)
        ) u_car (
            .clk    (clk),
            .rst_n  (rst_n),
            .peak   (peak_i),
            .cnt    (cnt_flat[k*CNT_W +: CNT_W]),
            .valley (valley[k])
        );
    end

    mcpwm_ref_hold #(
        .CNT_W (CNT_W)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (valley[0]),
        .ref_in (ref_i),
        .ref_q  (ref_q)
    );

    mcpwm_gate_map #(
        .CNT_W (CNT_W),
        .NCAR  (NCAR),
        .NG    (NG),
        .LW    (LW)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_i),
        .peak     (peak_i),
        .ref_q    (ref_q),
        .cnt_flat (cnt_flat),
        .gate     (gate_o),
        .level    (level_o)
    );
endmodule

// File: rtl/mcpwm_phase_leg_chk.sv
// Port-level checker for mcpwm_phase_leg, bound into every instance.
module mcpwm_phase_leg_chk
    import mcpwm_pkg::*;
#(
    parameter int NCAR  = 4,
    parameter int CNT_W = 16,
    localparam int NG   = 4 * NCAR - 4,
    localparam int LW   = $clog2(NCAR + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_i,
    input logic [NG-1:0] gate_o,
    input logic [LW-1:0] level_o
);
    logic [LW-1:0] on_cnt;

    // Purpose: count the "on" bits seen on the gate port
    always_comb begin
        on_cnt = '0;
        for (int k = 0; k < NCAR; k++) begin
            on_cnt = on_cnt + LW'(gate_o[gate_base(k)]);
        end
    end

    // R4: the first two pairs are exact complements while gating is active
    a_r4_pair_compl: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_o) |-> ((gate_o[0] ^ gate_o[1]) && (gate_o[2] ^ gate_o[3])));

    // R5: in-phase and complementary bits inside each group of four
    for (genvar k = 2; k < NCAR; k++) begin : g_quad
        localparam int B = gate_base(k);
        a_r5_group: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_o[B] == gate_o[B + 2]) && (gate_o[B + 1] == gate_o[B + 3])
            && (!(|gate_o) || (gate_o[B] ^ gate_o[B + 1])));
    end

    // R6: level equals the number of on bits while gating is active
    a_r6_level_match: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_o) |-> (level_o == on_cnt));

    // R6: level never exceeds the carrier count
    a_r6_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LW'(NCAR));

    // R8: an edge with enable low clears every gate bit
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (gate_o == '0));
endmodule

bind mcpwm_phase_leg mcpwm_phase_leg_chk #(
    .NCAR  (NCAR),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .gate_o  (gate_o),
    .level_o (level_o)
);

// File: tb/tb_mcpwm_phase_leg.sv
module tb_mcpwm_phase_leg;
    localparam int NCAR  = 4;
    localparam int CNT_W = 8;
    localparam int NG    = 4 * NCAR - 4;
    localparam int LW    = $clog2(NCAR + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  en_i = 1'b0;
    logic [CNT_W-1:0]      peak_i = 8'd8;
    logic signed [CNT_W:0] ref_i = '0;
    logic [NG-1:0]         gate_o;
    logic [LW-1:0]         level_o;

    int total = 0;
    int fails = 0;
    int P = 8;

    always #2 clk = ~clk;

    mcpwm_phase_leg #(.NCAR(NCAR), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .peak_i(peak_i),
        .ref_i(ref_i), .gate_o(gate_o), .level_o(level_o));

    // ---------- reference model built from the requirements ----------
    int                    mn;
    logic signed [CNT_W:0] mref;
    logic [NG-1:0]         mg;
    logic [LW-1:0]         ml;

    function automatic int carrier_at(input int k, input int n, input int pk);
        int ph;
        ph = (k * 2 * pk / NCAR + n) % (2 * pk);
        return (ph <= pk) ? ph : 2 * pk - ph;
    endfunction

    always @(posedge clk) begin
        logic [NG-1:0] g;
        int cnt_on;
        int b;
        if (!rst_n) begin
            mn <= 0; mref <= '0; mg <= '0; ml <= '0;
        end else begin
            g = '0; cnt_on = 0;
            for (int k = 0; k < NCAR; k++) begin
                logic on;
                on = (2 * carrier_at(k, mn, P)) < (int'(mref) + P);
                cnt_on += int'(on);
                b = (k < 2) ? 2 * k : 4 * k - 4;
                g[b] = on; g[b + 1] = ~on;
                if (k >= 2) begin g[b + 2] = on; g[b + 3] = ~on; end
            end
            mg <= en_i ? g : '0;
            ml <= LW'(cnt_on);
            if (carrier_at(0, mn, P) == 0) mref <= ref_i;
            mn <= (mn + 1) % (2 * P);
        end
    end

    // ---------- check helpers ----------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare outputs against the model for n cycles
    task automatic run_cmp(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(gate_o == mg, req, int'(gate_o), int'(mg));
            chk(level_o == ml, req, int'(level_o), int'(ml));
        end
    endtask

    task automatic do_reset(input int pk);
        @(negedge clk);
        rst_n = 1'b0; P = pk; peak_i = CNT_W'(pk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(gate_o == '0, "R1 gates in reset", int'(gate_o), 0);
            chk(level_o == '0, "R1 level in reset", int'(level_o), 0);
        end
        rst_n = 1'b1;
    endtask

    // Mid reference: all carriers toggle at their offsets
    task automatic t_mid(input int r);
        en_i = 1'b1; ref_i = (CNT_W+1)'(r);
        run_cmp(6 * P, "R2 R3 R4 R5 R6 sweep");
    endtask

    // Negative extreme: nothing on, level stays 0 once captured
    task automatic t_low();
        ref_i = -(CNT_W+1)'(P);
        run_cmp(2 * P, "R9 low settle");
        for (int i = 0; i < 2 * P; i++) begin
            @(negedge clk);
            chk(level_o == '0, "R9 low level", int'(level_o), 0);
            chk(gate_o == 12'hAAA, "R9 low gates", int'(gate_o), 12'hAAA);
        end
    endtask

    // Positive extreme: on except at each carrier's peak
    task automatic t_high();
        int lvl4 = 0;
        ref_i = (CNT_W+1)'(P);
        run_cmp(2 * P, "R9 high settle");
        for (int i = 0; i < 2 * P; i++) begin
            @(negedge clk);
            chk(gate_o == mg, "R9 high gates", int'(gate_o), int'(mg));
            if (level_o == LW'(4)) lvl4++;
        end
        // four peaks per period, each costs one cycle of full level
        chk(lvl4 == 2 * P - 4, "R9 high full-level count", lvl4, 2 * P - 4);
    endtask

    // Reference change away from the valley has no effect until the valley
    task automatic t_hold();
        ref_i = -(CNT_W+1)'(P);
        run_cmp(2 * P, "R7 preset");
        while (mn != P) @(negedge clk);
        ref_i = (CNT_W+1)'(P);
        @(negedge clk);
        chk(gate_o[0] == 1'b0, "R7 ignored mid-period", int'(gate_o[0]), 0);
        chk(level_o == '0, "R7 level unchanged", int'(level_o), 0);
        run_cmp(3 * P, "R7 capture at valley");
    endtask

    // Enable low: gates cleared, carriers keep running
    task automatic t_enable();
        int lvl_changes = 0;
        logic [LW-1:0] last;
        ref_i = '0;
        run_cmp(2 * P, "R8 pre");
        en_i = 1'b0;
        @(negedge clk);
        last = level_o;
        for (int i = 0; i < 2 * P; i++) begin
            @(negedge clk);
            chk(gate_o == '0, "R8 gates cleared", int'(gate_o), 0);
            chk(level_o == ml, "R8 level tracks", int'(level_o), int'(ml));
            if (level_o != last) lvl_changes++;
            last = level_o;
        end
        chk(lvl_changes > 0, "R8 carriers running", lvl_changes, 1);
        en_i = 1'b1;
        run_cmp(P, "R8 re-enable");
    endtask

    initial begin
        #(4 * 200000);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset(8);
        t_mid(0);
        t_mid(3);
        t_low();
        t_high();
        t_hold();
        t_enable();
        do_reset(6);
        t_mid(-2);
        t_mid(4);
        t_hold();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule